// File: doc/BRIEF.md
# H-Bridge Fault Supervisor

This block watches the protection detectors of an H-bridge power stage and decides when the gate logic must hold all four switches off. It takes three detector levels: a short circuit, an over-temperature and a high-side peak overcurrent. It also takes a current-limit comparator, two timing strobes from the PWM generator (switching-cycle start and switching edge) and a disable control. It drives one force-off line to the gate logic and three status flags.

Each detector level passes through a synchronizer and a persistence filter before it takes effect. The filter length is set on a configuration input. The status flags mix two behaviours. The fault flag is latched and is released only by a high-then-low pulse on the disable input. The short-circuit and temperature flags are live and track their filtered detectors. The current-limit comparator gives cycle-by-cycle limiting: once it trips, the bridge stays off until the next cycle start. The comparator is not looked at while the switching-edge strobe is high, because current spikes are expected then.

Top module: `bridge_fault_sup`

## Requirements
- R1: While reset is held, and after it is released with all inputs low, force_off, fault, sc_flag and tlim_flag are all 0.
- R2: A detector level takes effect only after it has been high for L consecutive clocks at the synchronizer output, where L = cfg_filt_len, and a value of 0 counts as 1. Shorter pulses have no effect on any output. A level driven high just after a clock edge shows its effect after L+2 rising edges.
- R3: sc_flag follows the filtered short-circuit detector and does not latch. While it is high, force_off is high. It does not set fault.
- R4: A filtered high-side overcurrent sets fault. fault then stays high after the detector goes low.
- R5: A filtered over-temperature sets fault while therm_en is 1. tlim_flag follows the filtered over-temperature detector (high = hot) and does not latch.
- R6: With therm_en at 0, the over-temperature detector has no effect: tlim_flag stays 0 and fault is not set.
- R7: fault is cleared only at the clock edge that sees disable_in low after it was high on the previous edge. The clear happens only if no filtered detector (short circuit, overcurrent, or over-temperature while enabled) is active at that edge. Otherwise fault stays set.
- R8: When ilim_cmp is sampled high, force_off goes high from the next clock. It stays high until the edge at which cyc_start is sampled high. That edge clears the limit unless ilim_cmp also trips in the same cycle.
- R9: ilim_cmp is ignored in any cycle in which sw_edge is high.
- R10: force_off is high exactly when at least one of these holds: fault is set, sc_flag is high, the current limit is active, or disable_in is high. disable_in acts on force_off without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_filt_len | input | CNT_W | Persistence filter length in clocks (0 acts as 1) |
| therm_en | input | 1 | 1 enables over-temperature protection |
| sc_det | input | 1 | Short-circuit detector level |
| ot_det | input | 1 | Over-temperature detector level |
| oc_det | input | 1 | High-side peak overcurrent detector level |
| ilim_cmp | input | 1 | Current-limit comparator, synchronous to clk |
| cyc_start | input | 1 | Switching-cycle start strobe |
| sw_edge | input | 1 | Switching-transition strobe (blanking) |
| disable_in | input | 1 | Disable control; a high-then-low pulse releases the fault latch |
| force_off | output | 1 | Hold all four bridge switches off |
| fault | output | 1 | Latched fault flag |
| sc_flag | output | 1 | Live short-circuit flag |
| tlim_flag | output | 1 | Live over-temperature flag |

## Verification
The assertions assume that ilim_cmp, cyc_start, sw_edge and disable_in are already synchronous to clk. They also assume that cfg_filt_len and therm_en change only while the detectors are quiet. The stimulus respects both: it changes every input just after a falling clock edge, and it reconfigures the filter and the thermal enable only between test phases, after every detector has returned low and the filters have drained. Detector pulses are whole clock periods long, so the persistence sweep maps one-to-one onto counts of synchronized cycles.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  localparam int NDET   = 3;
  localparam int IDX_SC = 0;
  localparam int IDX_OT = 1;
  localparam int IDX_OC = 2;
endpackage

// File: rtl/bfs_filter.sv
module bfs_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] len,
  input  logic             din,
  output logic             qual
);
  logic [SYNC_STAGES-1:0] sr;
  logic [CNT_W-1:0]       run, run_n;
  logic                   s;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] v);
    return (v == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : v;
  endfunction

  assign s     = sr[SYNC_STAGES-1];
  assign run_n = s ? sat_inc(run) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      run  <= '0;
      qual <= 1'b0;
    end else begin
      sr   <= {sr[SYNC_STAGES-2:0], din};
      run  <= run_n;
      qual <= s && (run_n >= eff_len(len));
    end
  end

  // R2: a synchronized low drops the qualified output on the next edge
  p_qual_needs_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !s |=> !qual);
  // R2: the run counter restarts after any synchronized low
  p_run_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !s |=> (run == '0));
endmodule

// File: rtl/bfs_fault_latch.sv
module bfs_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic any_active,
  input  logic dis_in,
  output logic fault,
  output logic dis_fall
);
  logic dis_q;

  assign dis_fall = dis_q & ~dis_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= 1'b0;
      fault <= 1'b0;
    end else begin
      dis_q <= dis_in;
      if (set_req)
        fault <= 1'b1;
      else if (dis_fall && !any_active)
        fault <= 1'b0;
    end
  end

  // R4: a qualified latching cause sets the fault on the next edge
  p_fault_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> fault);
  // R7: without a disable falling edge the fault holds
  p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !dis_fall) |=> fault);
  // R7: an active detector blocks the clear
  p_clear_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && any_active) |=> fault);
endmodule

// File: rtl/bfs_cycle_limit.sv
module bfs_cycle_limit (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp,
  input  logic blank,
  input  logic cyc_start,
  output logic limit
);
  logic trip;

  assign trip = cmp & ~blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) limit <= 1'b0;
    else        limit <= trip | (limit & ~cyc_start);
  end

  // R8: the limit holds until a cycle start
  p_limit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (limit && !cyc_start) |=> limit);
  // R8: an unblanked trip sets the limit
  p_limit_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp && !blank) |=> limit);
  // R9: a blanked comparator cannot start a limit
  p_limit_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && !limit) |=> !limit);
endmodule

// File: rtl/bridge_fault_sup.sv
module bridge_fault_sup #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_filt_len,
  input  logic             therm_en,
  input  logic             sc_det,
  input  logic             ot_det,
  input  logic             oc_det,
  input  logic             ilim_cmp,
  input  logic             cyc_start,
  input  logic             sw_edge,
  input  logic             disable_in,
  output logic             force_off,
  output logic             fault,
  output logic             sc_flag,
  output logic             tlim_flag
);
  import bfs_pkg::*;

  logic [NDET-1:0] det_raw, det_q;
  logic            sc_q, ot_q, oc_q, ot_live;
  logic            latch_set, any_active, dis_fall, limit;

  assign det_raw[IDX_SC] = sc_det;
  assign det_raw[IDX_OT] = ot_det;
  assign det_raw[IDX_OC] = oc_det;

  for (genvar i = 0; i < NDET; i++) begin : g_filt
    bfs_filter #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .len  (cfg_filt_len),
      .din  (det_raw[i]),
      .qual (det_q[i])
    );
  end

  assign sc_q       = det_q[IDX_SC];
  assign ot_q       = det_q[IDX_OT];
  assign oc_q       = det_q[IDX_OC];
  assign ot_live    = ot_q & therm_en;
  assign latch_set  = oc_q | ot_live;
  assign any_active = sc_q | oc_q | ot_live;

  bfs_fault_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_req   (latch_set),
    .any_active(any_active),
    .dis_in    (disable_in),
    .fault     (fault),
    .dis_fall  (dis_fall)
  );

  bfs_cycle_limit u_limit (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp      (ilim_cmp),
    .blank    (sw_edge),
    .cyc_start(cyc_start),
    .limit    (limit)
  );

  assign sc_flag   = sc_q;
  assign tlim_flag = ot_live;
  assign force_off = fault | sc_q | limit | disable_in;

  // R10: disable acts on force-off with no delay
  p_disable_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    disable_in |-> force_off);
  // R10: a latched fault keeps the bridge off
  p_fault_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> force_off);
  // R3: a short circuit alone never sets the latch
  p_sc_no_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && !oc_q && !ot_live) |=> !fault);
  // R6: a fault appears only with a latching cause on the previous edge
  p_fault_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(oc_q || (ot_q && therm_en)));
endmodule

// File: tb/sim_bridge_fault_sup.sv
module sim_bridge_fault_sup;
  localparam int CNT_W = 4;
  logic clk = 0, rst_n = 0;
  logic [CNT_W-1:0] cfg_filt_len = 4'd1;
  logic therm_en = 1, sc_det = 0, ot_det = 0, oc_det = 0;
  logic ilim_cmp = 0, cyc_start = 0, sw_edge = 0, disable_in = 0;
  logic force_off, fault, sc_flag, tlim_flag;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bridge_fault_sup #(.SYNC_STAGES(2), .CNT_W(CNT_W)) u0 (.*);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic release_fault();
    disable_in = 1; tick(1);
    disable_in = 0; tick(1);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    tick(2);
    // R1 reset state
    check("R1 force_off", force_off, 0);
    check("R1 fault", fault, 0);
    rst_n = 1; tick(2);
    check("R1 sc_flag", sc_flag, 0);
    check("R1 tlim_flag", tlim_flag, 0);
    check("R1 force_off after reset", force_off, 0);

    // R2/R3 sweep: filter length vs pulse width on the short-circuit detector
    for (int len = 0; len <= 4; len++) begin
      for (int w = 1; w <= 6; w++) begin
        automatic int eff = (len == 0) ? 1 : len;
        automatic bit seen = 0;
        cfg_filt_len = len[CNT_W-1:0];
        sc_det = 1;
        for (int c = 0; c < w; c++) begin tick(1); seen |= sc_flag; end
        sc_det = 0;
        for (int c = 0; c < 8; c++) begin tick(1); seen |= sc_flag; end
        check("R2 persistence sweep", seen, (w >= eff));
        check("R3 no latch from short", fault, 0);
      end
    end

    // R2 latency: effect after L+2 edges, not before
    for (int len = 1; len <= 4; len++) begin
      cfg_filt_len = len[CNT_W-1:0];
      sc_det = 1;
      tick(len + 1);
      check("R2 not yet", sc_flag, 0);
      tick(1);
      check("R2 latency", sc_flag, 1);
      check("R3 force_off with short", force_off, 1);
      sc_det = 0; tick(3);
      check("R3 live flag drops", sc_flag, 0);
      check("R10 force_off drops", force_off, 0);
    end

    // R4 overcurrent latches
    cfg_filt_len = 4'd2;
    oc_det = 1; tick(6); oc_det = 0; tick(6);
    check("R4 fault latched", fault, 1);
    check("R10 force_off from fault", force_off, 1);
    tick(10);
    check("R7 no clear without disable", fault, 1);
    disable_in = 1; tick(1);
    check("R7 still set while disable high", fault, 1);
    disable_in = 0; tick(1);
    check("R7 cleared on falling edge", fault, 0);
    check("R10 force_off clear", force_off, 0);

    // R5 over-temperature
    ot_det = 1; tick(6);
    check("R5 tlim live", tlim_flag, 1);
    check("R5 fault set", fault, 1);
    // R7 clear blocked while detector active
    release_fault();
    check("R7 clear blocked", fault, 1);
    ot_det = 0; tick(5);
    check("R5 tlim not latched", tlim_flag, 0);
    check("R5 fault stays", fault, 1);
    release_fault();
    check("R7 clear after detector gone", fault, 0);

    // R6 thermal protection disabled
    therm_en = 0; tick(1);
    ot_det = 1; tick(8);
    check("R6 tlim stays low", tlim_flag, 0);
    check("R6 fault not set", fault, 0);
    check("R6 force_off low", force_off, 0);
    ot_det = 0; tick(5);
    therm_en = 1; tick(1);
    check("R6 nothing after re-enable", fault, 0);

    // R8 cycle-by-cycle limit
    ilim_cmp = 1; tick(1); ilim_cmp = 0;
    check("R8 limit forces off", force_off, 1);
    tick(4);
    check("R8 limit holds in cycle", force_off, 1);
    cyc_start = 1; tick(1); cyc_start = 0;
    check("R8 cleared at cycle start", force_off, 0);
    // R8 trip in the same cycle as start wins
    ilim_cmp = 1; cyc_start = 1; tick(1); ilim_cmp = 0; cyc_start = 0;
    check("R8 trip with start", force_off, 1);
    cyc_start = 1; tick(1); cyc_start = 0;
    check("R8 cleared again", force_off, 0);
    check("R8 limit not latched", fault, 0);

    // R9 blanking
    sw_edge = 1; ilim_cmp = 1; tick(3); ilim_cmp = 0; sw_edge = 0; tick(1);
    check("R9 blanked trip ignored", force_off, 0);
    sw_edge = 1; ilim_cmp = 1; tick(1); sw_edge = 0; tick(1); ilim_cmp = 0;
    check("R9 trip after blanking ends", force_off, 1);
    cyc_start = 1; tick(1); cyc_start = 0;

    // R10 disable acts immediately
    @(posedge clk); #3 disable_in = 1; #1;
    check("R10 disable immediate", force_off, 1);
    tick(1); disable_in = 0; #1;
    check("R10 disable release", force_off, 0);

    finish_run();
  end
endmodule